// File: doc/BRIEF.md
# Scratch Pad Address Controller

This block forms the address for a general-purpose scratch pad kept in a 4-bit-wide DRAM. A command source gives it a quarter select, a page, a column and a row. The block checks that location against the legal ranges and packs it into two registers: a 7-bit row/column-address word and an 8-bit count word. The packing differs between the base region (quarter 0) and the three extra quarters that only exist with the larger DRAM. A configuration input selects the DRAM size.

The address is used in one of two ways. In random access, a full address is loaded before every location transfer, and one transfer consumes it. In sequential access, one start address is loaded. Each transfer then issued steps the row by one, until the last row of the column. A transfer request beyond that point raises an end-of-column flag instead of reaching the DRAM.

The block also shows whether a high-speed transfer is allowed. This is false while the slow-transfer window is open (the second half of time segment 0). In that window, each transfer is held back until the ready-for-transfer status is high.

Top module: `spad_addr_ctrl`

## Requirements
- R1: After reset, `rac_o`, `cnt_o` and `quarter_o` are zero, `err_o` and `eoc_o` are low, and no transfer is issued even with `xfer_req_i` high.
- R2: A valid load with quarter 0 sets `rac_o` = {page[2:0], col[2:0], 1'b1} and `cnt_o` = {2'b10, row[5:0]} at the next clock edge.
- R3: A valid load with quarter 1 to 3 sets `rac_o` = {page[2:0], col[2:0], row[8]}, `cnt_o` = row[7:0] and `quarter_o` = quarter at the next clock edge.
- R4: A load with page above 5 raises `err_o` at the next edge. So does a quarter-0 load with column 0 or row above 63, and a quarter 1–3 load with row above 431. Until a later valid load clears `err_o`, no transfer is issued.
- R5: With `big_dram_i` low, a load with a nonzero quarter is rejected with `err_o`. The same location is accepted with `big_dram_i` high.
- R6: In sequential mode (`seq_mode_i`=1 at load), each issued transfer below the last row raises the row by one at the clock edge that ends the transfer cycle. In quarters 1 to 3 the carry from `cnt_o` goes into `rac_o[0]`.
- R7: In sequential mode, a transfer at the last row (63 in quarter 0, 431 otherwise) is issued and leaves the row unchanged. The next request is not issued and sets `eoc_o` at that edge. `eoc_o` stays high until a load.
- R8: In random mode (`seq_mode_i`=0 at load), exactly one transfer is issued per load. Further requests are not issued and leave the address unchanged.
- R9: `hs_ok_o` is the inverse of `slow_win_i`. While `slow_win_i` is high, a transfer is issued only in a cycle with `rdy_i` high.
- R10: `xfer_go_o` rises in the same cycle as an accepted `xfer_req_i`, with the address of that transfer on `rac_o`/`cnt_o`. A request in a cycle with `load_i` high is not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| big_dram_i | input | 1 | 1 = larger DRAM, where quarters 1 to 3 are available |
| load_i | input | 1 | Load the location given on the select inputs |
| seq_mode_i | input | 1 | Access mode taken at load: 1 sequential, 0 random |
| quarter_i | input | 2 | Quarter select |
| page_i | input | 3 | Page number |
| col_i | input | 3 | Column number |
| row_i | input | 9 | Row number |
| xfer_req_i | input | 1 | Transfer request, held until issued |
| slow_win_i | input | 1 | Slow-transfer window status |
| rdy_i | input | 1 | Ready-for-transfer status |
| rac_o | output | 7 | Row/column-address register |
| cnt_o | output | 8 | Count register |
| quarter_o | output | 2 | Quarter of the loaded address |
| xfer_go_o | output | 1 | DRAM access issued this cycle |
| hs_ok_o | output | 1 | High-speed transfer allowed |
| err_o | output | 1 | Last load was out of range |
| eoc_o | output | 1 | Request made past the end of the column |

## Verification
If the row register is corrupted or steps wrongly, it shows on `rac_o`/`cnt_o` one edge after the transfer that should have stepped it. It shows through the constant marker bits in quarter 0, or through a missing carry into `rac_o[0]` in the upper quarters. If the armed or end-of-column state is wrong, it shows in the very next request cycle: `xfer_go_o` is either issued when it should not be or withheld when it should. `err_o` and `eoc_o` show a wrong flag update one edge after the load or request that caused it. The bench loads addresses next to every range limit and walks sequential runs across the column end and across the 255-to-256 carry.

// File: rtl/spad_pkg.sv
package spad_pkg;
  localparam int unsigned PAGE_W = 3;
  localparam int unsigned COL_W  = 3;
  localparam int unsigned ROW_W  = 9;
  localparam int unsigned QSEL_W = 2;
  localparam int unsigned RAC_W  = PAGE_W + COL_W + 1;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned Q0_ROW_W = CNT_W - 2;

  typedef enum logic {
    ACC_RANDOM = 1'b0,
    ACC_SEQ    = 1'b1
  } acc_mode_e;

  typedef struct packed {
    logic [QSEL_W-1:0] qsel;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
  } spad_loc_t;
endpackage

// File: rtl/spad_rst_sync.sv
module spad_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spad_range_chk.sv
module spad_range_chk
  import spad_pkg::*;
#(
  parameter int unsigned PAGE_CNT = 6,
  parameter int unsigned Q0_ROWS  = 64,
  parameter int unsigned QX_ROWS  = 432
) (
  input  logic      big_dram,
  input  spad_loc_t loc,
  output logic      loc_ok
);
  localparam logic [PAGE_W-1:0] PAGE_LAST = PAGE_W'(PAGE_CNT - 1);
  localparam logic [ROW_W-1:0]  Q0_LAST   = ROW_W'(Q0_ROWS - 1);
  localparam logic [ROW_W-1:0]  QX_LAST   = ROW_W'(QX_ROWS - 1);

  logic page_ok, q0_ok, qx_ok;

  always_comb begin
    page_ok = (loc.page <= PAGE_LAST);
    q0_ok   = (loc.col != '0) && (loc.row <= Q0_LAST);
    qx_ok   = big_dram && (loc.row <= QX_LAST);
    loc_ok  = page_ok && ((loc.qsel == '0) ? q0_ok : qx_ok);
  end
endmodule

// File: rtl/spad_addr_fmt.sv
module spad_addr_fmt
  import spad_pkg::*;
(
  input  spad_loc_t         loc,
  output logic [RAC_W-1:0]  rac,
  output logic [CNT_W-1:0]  cnt
);
  always_comb begin
    if (loc.qsel == '0) begin
      rac = {loc.page, loc.col, 1'b1};
      cnt = {2'b10, loc.row[Q0_ROW_W-1:0]};
    end else begin
      rac = {loc.page, loc.col, loc.row[ROW_W-1]};
      cnt = loc.row[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/spad_xfer_gate.sv
module spad_xfer_gate (
  input  logic xfer_req,
  input  logic load,
  input  logic armed,
  input  logic col_end,
  input  logic slow_win,
  input  logic rdy,
  output logic go,
  output logic eoc_hit,
  output logic hs_ok
);
  logic path_free;

  always_comb begin
    hs_ok     = ~slow_win;
    path_free = hs_ok | rdy;
    go        = xfer_req & ~load & armed & ~col_end & path_free;
    eoc_hit   = xfer_req & ~load & armed & col_end;
  end
endmodule

// File: rtl/spad_addr_ctrl.sv
module spad_addr_ctrl
  import spad_pkg::*;
#(
  parameter int unsigned PAGE_CNT   = 6,
  parameter int unsigned Q0_ROWS    = 64,
  parameter int unsigned QX_ROWS    = 432,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_dram_i,
  input  logic              load_i,
  input  logic              seq_mode_i,
  input  logic [QSEL_W-1:0] quarter_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              xfer_req_i,
  input  logic              slow_win_i,
  input  logic              rdy_i,
  output logic [RAC_W-1:0]  rac_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [QSEL_W-1:0] quarter_o,
  output logic              xfer_go_o,
  output logic              hs_ok_o,
  output logic              err_o,
  output logic              eoc_o
);
  localparam logic [ROW_W-1:0] Q0_LAST = ROW_W'(Q0_ROWS - 1);
  localparam logic [ROW_W-1:0] QX_LAST = ROW_W'(QX_ROWS - 1);

  logic rst_sync_n;

  spad_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // state registers and their next values
  logic [RAC_W-1:0]  rac_q, rac_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [QSEL_W-1:0] qsel_q, qsel_d;
  acc_mode_e         mode_q, mode_d;
  logic              armed_q, armed_d;
  logic              end_q, end_d;
  logic              eoc_q, eoc_d;
  logic              err_q, err_d;

  // incoming location
  spad_loc_t  ld_loc;
  logic       ld_ok;
  logic [RAC_W-1:0] ld_rac;
  logic [CNT_W-1:0] ld_cnt;

  assign ld_loc = '{qsel: quarter_i, page: page_i, col: col_i, row: row_i};

  spad_range_chk #(
    .PAGE_CNT (PAGE_CNT),
    .Q0_ROWS  (Q0_ROWS),
    .QX_ROWS  (QX_ROWS)
  ) u_chk (
    .big_dram (big_dram_i),
    .loc      (ld_loc),
    .loc_ok   (ld_ok)
  );

  spad_addr_fmt u_fmt_ld (
    .loc (ld_loc),
    .rac (ld_rac),
    .cnt (ld_cnt)
  );

  // current row unpacked from the registers, and its successor repacked
  logic [ROW_W-1:0] row_cur;
  logic             at_last;
  spad_loc_t        step_loc;
  logic [RAC_W-1:0] step_rac;
  logic [CNT_W-1:0] step_cnt;

  always_comb begin
    if (qsel_q == '0) begin
      row_cur = {{(ROW_W-Q0_ROW_W){1'b0}}, cnt_q[Q0_ROW_W-1:0]};
      at_last = (row_cur == Q0_LAST);
    end else begin
      row_cur = {rac_q[0], cnt_q};
      at_last = (row_cur == QX_LAST);
    end
    step_loc = '{qsel: qsel_q,
                 page: rac_q[RAC_W-1 -: PAGE_W],
                 col:  rac_q[COL_W:1],
                 row:  row_cur + ROW_W'(1)};
  end

  spad_addr_fmt u_fmt_step (
    .loc (step_loc),
    .rac (step_rac),
    .cnt (step_cnt)
  );

  logic go, eoc_hit, hs_ok;

  spad_xfer_gate u_gate (
    .xfer_req (xfer_req_i),
    .load     (load_i),
    .armed    (armed_q),
    .col_end  (end_q),
    .slow_win (slow_win_i),
    .rdy      (rdy_i),
    .go       (go),
    .eoc_hit  (eoc_hit),
    .hs_ok    (hs_ok)
  );

  // next-state
  always_comb begin
    rac_d   = rac_q;
    cnt_d   = cnt_q;
    qsel_d  = qsel_q;
    mode_d  = mode_q;
    armed_d = armed_q;
    end_d   = end_q;
    eoc_d   = eoc_q;
    err_d   = err_q;
    if (load_i) begin
      eoc_d = 1'b0;
      end_d = 1'b0;
      if (ld_ok) begin
        rac_d   = ld_rac;
        cnt_d   = ld_cnt;
        qsel_d  = quarter_i;
        mode_d  = seq_mode_i ? ACC_SEQ : ACC_RANDOM;
        armed_d = 1'b1;
        err_d   = 1'b0;
      end else begin
        armed_d = 1'b0;
        err_d   = 1'b1;
      end
    end else if (go) begin
      if (mode_q == ACC_RANDOM) begin
        armed_d = 1'b0;
      end else if (at_last) begin
        end_d = 1'b1;
      end else begin
        rac_d = step_rac;
        cnt_d = step_cnt;
      end
    end else if (eoc_hit) begin
      eoc_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rac_q   <= '0;
      cnt_q   <= '0;
      qsel_q  <= '0;
      mode_q  <= ACC_RANDOM;
      armed_q <= 1'b0;
      end_q   <= 1'b0;
      eoc_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rac_q   <= rac_d;
      cnt_q   <= cnt_d;
      qsel_q  <= qsel_d;
      mode_q  <= mode_d;
      armed_q <= armed_d;
      end_q   <= end_d;
      eoc_q   <= eoc_d;
      err_q   <= err_d;
    end
  end

  assign rac_o     = rac_q;
  assign cnt_o     = cnt_q;
  assign quarter_o = qsel_q;
  assign xfer_go_o = go;
  assign hs_ok_o   = hs_ok;
  assign err_o     = err_q;
  assign eoc_o     = eoc_q;

  // R2
  q0_marker_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed_q && qsel_q == '0) |-> (rac_q[0] && cnt_q[CNT_W-1 -: 2] == 2'b10));

  // R4
  err_blocks_go_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_q |-> !xfer_go_o);

  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_go_o && mode_q == ACC_SEQ && !at_last) |=> (row_cur == $past(row_cur) + ROW_W'(1)));

  // R7
  eoc_no_go_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eoc_q |-> !xfer_go_o);

  // R8
  rand_once_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_go_o && mode_q == ACC_RANDOM) |=> !xfer_go_o);

  // R9
  slow_wait_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (slow_win_i && !rdy_i) |-> !xfer_go_o);
endmodule

// File: tb/spad_addr_ctrl_tb.sv
module spad_addr_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       big_dram_i = 1'b0;
  logic       load_i = 1'b0;
  logic       seq_mode_i = 1'b0;
  logic [1:0] quarter_i = '0;
  logic [2:0] page_i = '0;
  logic [2:0] col_i = '0;
  logic [8:0] row_i = '0;
  logic       xfer_req_i = 1'b0;
  logic       slow_win_i = 1'b0;
  logic       rdy_i = 1'b0;
  logic [6:0] rac_o;
  logic [7:0] cnt_o;
  logic [1:0] quarter_o;
  logic       xfer_go_o, hs_ok_o, err_o, eoc_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spad_addr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .big_dram_i(big_dram_i), .load_i(load_i),
    .seq_mode_i(seq_mode_i), .quarter_i(quarter_i), .page_i(page_i),
    .col_i(col_i), .row_i(row_i), .xfer_req_i(xfer_req_i),
    .slow_win_i(slow_win_i), .rdy_i(rdy_i), .rac_o(rac_o), .cnt_o(cnt_o),
    .quarter_o(quarter_o), .xfer_go_o(xfer_go_o), .hs_ok_o(hs_ok_o),
    .err_o(err_o), .eoc_o(eoc_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive a load across one edge; returns 1 ns after the edge
  task automatic do_load(input bit seq, input int q, input int p, input int c, input int r);
    @(negedge clk);
    load_i = 1'b1; seq_mode_i = seq;
    quarter_i = 2'(q); page_i = 3'(p); col_i = 3'(c); row_i = 9'(r);
    @(posedge clk); #1;
    load_i = 1'b0;
  endtask

  // request one cycle; go is sampled mid-cycle
  task automatic do_req(output bit go);
    @(negedge clk);
    xfer_req_i = 1'b1;
    #1 go = xfer_go_o;
    @(posedge clk); #1;
    xfer_req_i = 1'b0;
  endtask

  function automatic int row_of(input int q);
    if (q == 0) return int'(cnt_o[5:0]);
    return int'({rac_o[0], cnt_o});
  endfunction

  task automatic t_reset();
    @(negedge clk);
    xfer_req_i = 1'b1;
    #1;
    check("R1 rac", rac_o, 0);
    check("R1 cnt", cnt_o, 0);
    check("R1 quarter", quarter_o, 0);
    check("R1 err", err_o, 0);
    check("R1 eoc", eoc_o, 0);
    check("R1 go", xfer_go_o, 0);
    @(posedge clk); #1;
    xfer_req_i = 1'b0;
  endtask

  task automatic t_pack();
    do_load(1'b0, 0, 5, 7, 63);
    check("R2 rac", rac_o, 7'b101_111_1);
    check("R2 cnt", cnt_o, 8'b10_111111);
    check("R2 err", err_o, 0);
    big_dram_i = 1'b1;
    do_load(1'b0, 3, 4, 0, 431);
    check("R3 rac", rac_o, {3'd4, 3'd0, 1'b1});
    check("R3 cnt", cnt_o, 431 & 8'hff);
    check("R3 quarter", quarter_o, 3);
    do_load(1'b0, 2, 1, 6, 200);
    check("R3 rac lowrow", rac_o, {3'd1, 3'd6, 1'b0});
    check("R3 cnt lowrow", cnt_o, 200);
  endtask

  task automatic t_range();
    bit go;
    big_dram_i = 1'b1;
    do_load(1'b0, 0, 6, 1, 0);
    check("R4 page6 err", err_o, 1);
    do_req(go);
    check("R4 no go after err", go, 0);
    do_load(1'b0, 0, 0, 1, 0);
    check("R4 valid clears err", err_o, 0);
    do_load(1'b0, 0, 0, 0, 0);
    check("R4 col0 err", err_o, 1);
    do_load(1'b0, 0, 0, 1, 64);
    check("R4 row64 err", err_o, 1);
    do_load(1'b0, 1, 0, 0, 432);
    check("R4 row432 err", err_o, 1);
    do_load(1'b0, 1, 5, 0, 431);
    check("R4 row431 ok", err_o, 0);
  endtask

  task automatic t_small();
    big_dram_i = 1'b0;
    do_load(1'b0, 2, 1, 1, 5);
    check("R5 small quarter err", err_o, 1);
    big_dram_i = 1'b1;
    do_load(1'b0, 2, 1, 1, 5);
    check("R5 big quarter ok", err_o, 0);
  endtask

  task automatic t_seq_q0();
    bit go;
    big_dram_i = 1'b0;
    do_load(1'b1, 0, 3, 2, 61);
    do_req(go);
    check("R10 go seq", go, 1);
    check("R6 row 62", row_of(0), 62);
    check("R6 marker", cnt_o[7:6], 2);
    do_req(go);
    check("R6 row 63", row_of(0), 63);
    do_req(go);
    check("R7 go at last", go, 1);
    check("R7 row held", row_of(0), 63);
    check("R7 eoc low yet", eoc_o, 0);
    do_req(go);
    check("R7 no go past end", go, 0);
    check("R7 eoc set", eoc_o, 1);
    do_load(1'b1, 0, 3, 2, 0);
    check("R7 load clears eoc", eoc_o, 0);
  endtask

  task automatic t_seq_qx();
    bit go;
    big_dram_i = 1'b1;
    do_load(1'b1, 1, 2, 3, 255);
    do_req(go);
    check("R6 carry rac", rac_o, {3'd2, 3'd3, 1'b1});
    check("R6 carry cnt", cnt_o, 0);
    do_load(1'b1, 3, 0, 7, 430);
    do_req(go);
    check("R6 qx row 431", row_of(3), 431);
    do_req(go);
    check("R7 qx go at last", go, 1);
    do_req(go);
    check("R7 qx no go", go, 0);
    check("R7 qx eoc", eoc_o, 1);
  endtask

  task automatic t_random();
    bit go;
    do_load(1'b0, 0, 2, 3, 10);
    do_req(go);
    check("R8 first go", go, 1);
    check("R8 addr kept", cnt_o, 8'b10_001010);
    do_req(go);
    check("R8 second no go", go, 0);
    check("R8 addr unchanged", rac_o, 7'b010_011_1);
    // request during a load cycle
    @(negedge clk);
    load_i = 1'b1; seq_mode_i = 1'b0; quarter_i = 0; page_i = 1; col_i = 1; row_i = 1;
    xfer_req_i = 1'b1;
    #1 check("R10 no go on load", xfer_go_o, 0);
    @(posedge clk); #1;
    load_i = 1'b0;
    #1 check("R10 go after load", xfer_go_o, 1);
    @(posedge clk); #1;
    xfer_req_i = 1'b0;
  endtask

  task automatic t_slow();
    bit go;
    do_load(1'b1, 0, 0, 4, 20);
    @(negedge clk);
    slow_win_i = 1'b1; rdy_i = 1'b0;
    #1 check("R9 hs_ok low", hs_ok_o, 0);
    do_req(go);
    check("R9 wait no go", go, 0);
    check("R9 row unchanged", row_of(0), 20);
    rdy_i = 1'b1;
    do_req(go);
    check("R9 go with rdy", go, 1);
    check("R9 row stepped", row_of(0), 21);
    slow_win_i = 1'b0; rdy_i = 1'b0;
    #1 check("R9 hs_ok high", hs_ok_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_pack();
    t_range();
    t_small();
    t_seq_q0();
    t_seq_qx();
    t_random();
    t_slow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule